// File: doc/BRIEF.md
# Two-Slot Edge Capture Unit

This block timestamps transitions on an external pin. The pin is resynchronised into the core clock. On each qualifying edge, the value of a free-running counter supplied from outside is stored. Up to two timestamps are stored in order, in slot A and then slot B. After two stores the unit ignores further edges until the capture count is cleared. A configuration bit chooses whether the one-cycle capture event strobe fires after the first store or after the second. Measuring a pulse width or a period with one interrupt therefore needs no software step between the two edges.

The surrounding timer owns interrupt status, register access and the counter itself. It feeds this unit the counter value, the edge mode, the slot-select bit, the pin direction and a clear pulse. The clear pulse is raised when software acknowledges a capture event.

The block has no streaming data path. The stored values are register-style outputs that hold until they are overwritten, so no valid/ready handshake or back-pressure applies. The strobe is a plain one-cycle pulse that the consumer must sample every cycle.

Top module: `dual_edge_capture`

## Requirements
- R1: `edge_mode_i` selects the qualifying edge of the synchronised pin: 0 none, 1 rising, 2 falling, 3 either edge. In mode 0 no edge is ever stored.
- R2: `pin_i` is sampled by a two-flop synchroniser. A pin change driven before clock edge k is stored, with the `count_i` value present just before edge k+2, at edge k+2. `event_o` is high for exactly the one cycle following that edge.
- R3: The first store after a clear writes `cap_a_o` and the second writes `cap_b_o`. Further qualifying edges leave both outputs unchanged until the count is cleared.
- R4: With `second_sel_i` low, `event_o` pulses after the store to slot A only. With it high, `event_o` pulses after the store to slot B only.
- R5: While `pin_is_input_i` is low, qualifying edges store nothing and raise no event.
- R6: A high `count_clr_i` at a clock edge resets the store count to zero. The stored values are not changed by the clear.
- R7: A change of `edge_mode_i` from 0 to any nonzero value resets the store count. A change between two nonzero modes does not.
- R8: A qualifying edge in the same cycle as a clear is stored as the first capture of the new sequence, into slot A.
- R9: After reset both stored values are zero, `event_o` is low and the store count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W | Counter value to timestamp |
| edge_mode_i | input | 2 | Edge selection (0 none, 1 rise, 2 fall, 3 both) |
| second_sel_i | input | 1 | 0: event after first store, 1: after second |
| pin_is_input_i | input | 1 | Pin configured as input; captures allowed |
| count_clr_i | input | 1 | Resets the store count |
| cap_a_o | output | CNT_W | First stored timestamp |
| cap_b_o | output | CNT_W | Second stored timestamp |
| event_o | output | 1 | One-cycle capture event strobe |

## Verification
The bench builds the unit with its default 32-bit counter width and two synchroniser stages. It gives every edge a distinct full-width stamp, including values with the top bit set, so a mixed-up slot or a truncated store shows. With the fixed three-cycle pin-to-strobe latency, every edge can be lined up exactly with a clear pulse. This puts the clear-versus-edge collision within reach, as well as the mode-change clear and its absence between two nonzero modes.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int unsigned SLOTS = 2;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       hit_o,
  output logic       arm_clr_o
);
  logic       prev_q;
  edge_mode_e mode, mode_q;
  logic       rise, fall;

  assign mode = edge_mode_e'(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      mode_q <= EDGE_OFF;
    end else begin
      prev_q <= lvl_i;
      mode_q <= mode;
    end
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  assign arm_clr_o = (mode_q == EDGE_OFF) && (mode != EDGE_OFF);

  a_r1_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF) |-> !hit_o);
  a_r1_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && mode == EDGE_RISE) |-> (lvl_i && !prev_q));
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             dir_in_i,
  input  logic             second_sel_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             event_o
);
  localparam int unsigned NW = $clog2(SLOTS + 1);

  logic [NW-1:0]    n_q, n_base;
  logic             take;
  logic [CNT_W-1:0] slot_q [SLOTS];

  assign n_base = clr_i ? '0 : n_q;
  assign take   = hit_i && dir_in_i && (n_base < NW'(SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q     <= '0;
      event_o <= 1'b0;
    end else begin
      n_q     <= take ? n_base + NW'(1) : n_base;
      event_o <= take && (n_base == NW'(second_sel_i));
    end
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q[s] <= '0;
        else if (take && n_base == NW'(s)) slot_q[s] <= count_i;
      end
    end
  endgenerate

  assign cap_a_o = slot_q[0];
  assign cap_b_o = slot_q[1];

  a_r3_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= NW'(SLOTS));
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q == NW'(SLOTS) && !clr_i) |=> ($stable(cap_a_o) && $stable(cap_b_o) && !event_o));
  a_r5_output_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_in_i |=> ($stable(cap_a_o) && $stable(cap_b_o) && !event_o));
  a_r4_event_cause: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(hit_i && dir_in_i));
  a_r6_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> ($stable(cap_a_o) && $stable(cap_b_o)));
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       edge_mode_i,
  input  logic             second_sel_i,
  input  logic             pin_is_input_i,
  input  logic             count_clr_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             event_o
);
  logic pin_s, hit, arm_clr;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s));

  cap_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(pin_s), .mode_i(edge_mode_i),
    .hit_o(hit), .arm_clr_o(arm_clr));

  cap_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .dir_in_i(pin_is_input_i),
    .second_sel_i(second_sel_i), .clr_i(count_clr_i | arm_clr),
    .count_i(count_i), .cap_a_o(cap_a_o), .cap_b_o(cap_b_o),
    .event_o(event_o));
endmodule

// File: tb/dual_edge_capture_tb.sv
module dual_edge_capture_tb;
  localparam int unsigned CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [1:0]    mode = 2'd0;
  logic          sel = 1'b0;
  logic          dir_in = 1'b1;
  logic          clr = 1'b0;
  logic [CW-1:0] cap_a, cap_b;
  logic          ev;

  int checks = 0;
  int fails  = 0;

  typedef struct { int slot; logic [CW-1:0] val; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  dual_edge_capture #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(cnt),
    .edge_mode_i(mode), .second_sel_i(sel), .pin_is_input_i(dir_in),
    .count_clr_i(clr), .cap_a_o(cap_a), .cap_b_o(cap_b), .event_o(ev));

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: every strobe pops the expected capture and compares it
  always @(negedge clk) begin
    if (rst_n && ev) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected event act=1 exp=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (((e.slot == 0) ? cap_a : cap_b) !== e.val) begin
          fails++;
          $display("FAIL R4 scoreboard slot%0d act=%h exp=%h", e.slot,
                   (e.slot == 0) ? cap_a : cap_b, e.val);
        end
      end
    end
  end

  // Drive a pin level with a stamp; optional clear aligned with the detect cycle
  task automatic step(input logic lvl, input logic [CW-1:0] stamp, input bit clr_hit,
                      input string req, input logic [CW-1:0] ea, input logic [CW-1:0] eb,
                      input bit eev, input int eslot);
    if (eev) exp_q.push_back('{slot: eslot, val: stamp});
    @(negedge clk); pin = lvl; cnt = stamp;
    @(negedge clk);
    @(negedge clk); clr = clr_hit;
    @(negedge clk); clr = 1'b0;
    check({req, " cap_a"}, cap_a, ea);
    check({req, " cap_b"}, cap_b, eb);
    check({req, " event"}, CW'(ev), CW'(eev));
    @(negedge clk);
    check({req, " single-cycle event"}, CW'(ev), '0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset cap_a", cap_a, '0);
    check("R9 reset cap_b", cap_b, '0);
    check("R9 reset event", CW'(ev), '0);

    // R1 mode off: no store
    step(1'b1, 32'h0000_0011, 0, "R1 off", '0, '0, 0, 0);
    step(1'b0, 32'h0000_0012, 0, "R1 off", '0, '0, 0, 0);

    // R2/R3/R4 rising, event on first
    mode = 2'd1; sel = 1'b0;
    step(1'b1, 32'hA000_0001, 0, "R2 R4 rise first", 32'hA000_0001, '0, 1, 0);
    step(1'b0, 32'hA000_0002, 0, "R1 fall ignored in rise", 32'hA000_0001, '0, 0, 0);
    step(1'b1, 32'hA000_0003, 0, "R3 second slot", 32'hA000_0001, 32'hA000_0003, 0, 0);
    step(1'b0, 32'hA000_0004, 0, "R3 idle", 32'hA000_0001, 32'hA000_0003, 0, 0);
    step(1'b1, 32'hA000_0005, 0, "R3 full ignored", 32'hA000_0001, 32'hA000_0003, 0, 0);

    // R7 nonzero to nonzero change does not clear
    mode = 2'd3;
    step(1'b0, 32'hA000_0006, 0, "R7 no clear rise->any", 32'hA000_0001, 32'hA000_0003, 0, 0);

    // R6 clear, falling mode, event on second
    mode = 2'd2; sel = 1'b1;
    pulse_clr();
    check("R6 clear keeps cap_a", cap_a, 32'hA000_0001);
    step(1'b1, 32'hB000_0001, 0, "R1 rise ignored in fall", 32'hA000_0001, 32'hA000_0003, 0, 0);
    step(1'b0, 32'hB000_0002, 0, "R6 R4 first no event", 32'hB000_0002, 32'hA000_0003, 0, 0);
    step(1'b1, 32'hB000_0003, 0, "R1 rise ignored", 32'hB000_0002, 32'hA000_0003, 0, 0);
    step(1'b0, 32'hB000_0004, 0, "R4 second event", 32'hB000_0002, 32'hB000_0004, 1, 1);

    // R7 off -> any clears the count
    mode = 2'd0; @(negedge clk); @(negedge clk);
    mode = 2'd3;
    step(1'b1, 32'hC000_0001, 0, "R7 any first", 32'hC000_0001, 32'hB000_0004, 0, 0);
    step(1'b0, 32'hC000_0002, 0, "R7 R1 any second", 32'hC000_0001, 32'hC000_0002, 1, 1);

    // R5 pin as output
    dir_in = 1'b0;
    pulse_clr();
    step(1'b1, 32'hD000_0001, 0, "R5 output dir", 32'hC000_0001, 32'hC000_0002, 0, 0);
    dir_in = 1'b1;

    // R8 edge in clear cycle: count full before, stored as first
    sel = 1'b0;
    step(1'b0, 32'hE000_0001, 0, "R8 setup", 32'hE000_0001, 32'hC000_0002, 1, 0);
    step(1'b1, 32'hE000_0002, 0, "R8 setup2", 32'hE000_0001, 32'hE000_0002, 0, 0);
    step(1'b0, 32'hE000_0003, 1, "R8 clear collide", 32'hE000_0003, 32'hE000_0002, 1, 0);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", CW'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule